// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Interface

This block is a byte-wide register file for a real-time clock, reached through two ports. The host first writes a register number into the index port. It then reads or writes the data port, and the access goes to the selected register. Indices 0 through 9 hold the date and time bytes and the alarm bytes. Indices 10 through 13 are the four status registers, named A, B, C and D here. Some writes are outside what the block supports: an index above 13, a status value the block cannot honour, or any write to C or D. Each of these raises a one-cycle error flag and changes nothing.

At reset the clock bytes load a start date taken from parameters. The year is encoded in one of two ways, chosen by a parameter: two BCD digits of the year modulo 100, or the number of years since 1900. The block does not advance time by itself. A periodic interrupt generator produces a one-cycle request every `TICK_CYCLES` clocks. It runs only while the enable bit in status B is set. Each read of status A inverts that register's update-in-progress bit.

Top module: `cmos_clock_regs`

## Requirements
- R1: An index write of 0..13 selects that register. An index write above 13 pulses `err` in the next cycle and keeps the old index.
- R2: Indices 0..9 are plain bytes. A data write stores the byte, and a later read returns it unchanged.
- R3: Status A (index 10) resets to 0x26. Each read first inverts bit 7 and then returns the new value, so consecutive reads alternate bit 7.
- R4: A data write of exactly 0x26 to status A is stored. Any other value pulses `err` and leaves status A unchanged.
- R5: Status B (index 11) resets to 0x46. A write is accepted and stored only if, with bits 6 and 3 masked off, the value equals 0x06. Otherwise it pulses `err` and leaves B unchanged.
- R6: Reads of status C and D (indices 12, 13) return 0x00. Writes to them pulse `err`.
- R7: While status B bit 6 is set, `irq` pulses high for one cycle every `TICK_CYCLES` cycles. While bit 6 is clear, `irq` stays low.
- R8: After reset, indices 0, 2, 4, 6, 7, 8 and 9 hold the start seconds, minutes, hours, day of week (1 = Sunday), day of month, month (1..12) and year. The alarm bytes 1, 3 and 5 hold 0.
- R9: The year byte is ((Y mod 100)/10 << 4) | (Y mod 10) when `YEAR_BCD` is 1, and Y − 1900 otherwise.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after `dat_re`. `rd_valid` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Write `wr_data` to the index port |
| dat_we | input | 1 | Write `wr_data` to the selected register |
| dat_re | input | 1 | Read the selected register |
| wr_data | input | DATA_W | Write byte for the index or data port |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| err | output | 1 | One-cycle flag for an unsupported write |
| irq | output | 1 | One-cycle periodic interrupt request |

## Verification
The assertions assume that at most one of `idx_we`, `dat_we` and `dat_re` is high in a cycle. The bench's access tasks raise a single strobe for one cycle and then drop it, so this holds throughout. The timer checks also assume `TICK_CYCLES` is at least 2, which makes every pulse followed by a low cycle. The bench uses a period of 8. Status writes are swept over all 256 byte values, and every rejected write is followed by a read-back, which shows that the register did not change.

// File: rtl/cmos_clock_pkg.sv
package cmos_clock_pkg;
  localparam int REG_BITS   = 8;
  localparam int IDX_W      = 4;
  localparam int NUM_BYTES  = 10;
  localparam int IDX_STAT_A = 10;
  localparam int IDX_STAT_B = 11;
  localparam int IDX_STAT_C = 12;
  localparam int IDX_STAT_D = 13;
  localparam int IDX_MAX    = IDX_STAT_D;

  localparam logic [REG_BITS-1:0] A_UIP_MASK  = 8'h80;
  localparam logic [REG_BITS-1:0] A_DEFAULT   = 8'h26;
  localparam logic [REG_BITS-1:0] B_DEFAULT   = 8'h46;
  localparam logic [REG_BITS-1:0] B_FREE_MASK = 8'h48;
  localparam logic [REG_BITS-1:0] B_REQUIRED  = 8'h06;
  localparam int                  B_PIE_BIT   = 6;

  function automatic logic [REG_BITS-1:0] year_code(input int year, input bit as_bcd);
    int yy;
    yy = year % 100;
    if (as_bcd) year_code = {4'(yy / 10), 4'(yy % 10)};
    else        year_code = REG_BITS'(year - 1900);
  endfunction
endpackage

// File: rtl/cmos_byte_store.sv
module cmos_byte_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 10,
  parameter int ADDR_W = 4,
  parameter logic [DEPTH*DATA_W-1:0] INIT_IMG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_IMG[i*DATA_W +: DATA_W];
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/cmos_status_ctl.sv
module cmos_status_ctl
  import cmos_clock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              reject,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] stat_q
);
  logic a_ok, b_ok;

  assign a_ok = (wdata == DATA_W'(A_DEFAULT));
  assign b_ok = ((wdata & ~DATA_W'(B_FREE_MASK)) == DATA_W'(B_REQUIRED));

  always_comb begin
    case (sel)
      IDX_W'(IDX_STAT_A): reject = !a_ok;
      IDX_W'(IDX_STAT_B): reject = !b_ok;
      default:            reject = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a  <= DATA_W'(A_DEFAULT);
      reg_b  <= DATA_W'(B_DEFAULT);
      stat_q <= '0;
    end else begin
      if (we && sel == IDX_W'(IDX_STAT_A) && a_ok) reg_a <= wdata;
      else if (re && sel == IDX_W'(IDX_STAT_A))    reg_a <= reg_a ^ DATA_W'(A_UIP_MASK);
      if (we && sel == IDX_W'(IDX_STAT_B) && b_ok) reg_b <= wdata;
      if (re) begin
        case (sel)
          IDX_W'(IDX_STAT_A): stat_q <= reg_a ^ DATA_W'(A_UIP_MASK);
          IDX_W'(IDX_STAT_B): stat_q <= reg_b;
          default:            stat_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmos_tick_gen.sv
module cmos_tick_gen #(
  parameter int TICK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pulse
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/cmos_clock_regs.sv
module cmos_clock_regs
  import cmos_clock_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TICK_CYCLES = 8,
  parameter bit YEAR_BCD    = 1'b1,
  parameter int INIT_YEAR   = 2024,
  parameter int INIT_MONTH  = 3,
  parameter int INIT_MDAY   = 15,
  parameter int INIT_WDAY   = 6,
  parameter int INIT_HOUR   = 13,
  parameter int INIT_MIN    = 45,
  parameter int INIT_SEC    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err,
  output logic              irq
);
  localparam int IMG_W = NUM_BYTES * DATA_W;

  function automatic logic [IMG_W-1:0] build_img();
    logic [IMG_W-1:0] img;
    img = '0;
    img[0*DATA_W +: DATA_W] = DATA_W'(INIT_SEC);
    img[2*DATA_W +: DATA_W] = DATA_W'(INIT_MIN);
    img[4*DATA_W +: DATA_W] = DATA_W'(INIT_HOUR);
    img[6*DATA_W +: DATA_W] = DATA_W'(INIT_WDAY);
    img[7*DATA_W +: DATA_W] = DATA_W'(INIT_MDAY);
    img[8*DATA_W +: DATA_W] = DATA_W'(INIT_MONTH);
    img[9*DATA_W +: DATA_W] = DATA_W'(year_code(INIT_YEAR, YEAR_BCD));
    return img;
  endfunction

  localparam logic [IMG_W-1:0] INIT_IMG = build_img();

  logic [IDX_W-1:0]  idx_q;
  logic              idx_bad;
  logic              in_bytes;
  logic              from_store_q;
  logic              stat_reject;
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] reg_a;
  logic [DATA_W-1:0] reg_b;

  assign idx_bad  = (wr_data > DATA_W'(IDX_MAX));
  assign in_bytes = (idx_q < IDX_W'(NUM_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q        <= '0;
      err          <= 1'b0;
      rd_valid     <= 1'b0;
      from_store_q <= 1'b0;
    end else begin
      if (idx_we && !idx_bad) idx_q <= wr_data[IDX_W-1:0];
      err      <= (idx_we && idx_bad) || (dat_we && !in_bytes && stat_reject);
      rd_valid <= dat_re;
      if (dat_re) from_store_q <= in_bytes;
    end
  end

  cmos_byte_store #(
    .DATA_W(DATA_W), .DEPTH(NUM_BYTES), .ADDR_W(IDX_W), .INIT_IMG(INIT_IMG)
  ) u_store (
    .clk(clk), .rst(rst),
    .we(dat_we && in_bytes), .re(dat_re && in_bytes),
    .addr(idx_q), .wdata(wr_data), .rdata(store_q)
  );

  cmos_status_ctl #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .we(dat_we && !in_bytes), .re(dat_re && !in_bytes),
    .sel(idx_q), .wdata(wr_data),
    .reject(stat_reject), .reg_a(reg_a), .reg_b(reg_b), .stat_q(stat_q)
  );

  cmos_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .run(reg_b[B_PIE_BIT]), .pulse(irq)
  );

  assign rd_data = from_store_q ? store_q : stat_q;
endmodule

// File: rtl/cmos_clock_regs_chk.sv
module cmos_clock_regs_chk
  import cmos_clock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              idx_we,
  input logic              dat_we,
  input logic              dat_re,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              err,
  input logic              irq,
  input logic [IDX_W-1:0]  idx_q,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b
);
  // R1
  idx_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_we && wr_data > DATA_W'(IDX_MAX)) |=> ($stable(idx_q) && err));

  // R3
  uip_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_re && idx_q == IDX_W'(IDX_STAT_A)) |=> (reg_a[7] != $past(reg_a[7])));

  // R4
  a_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_we && idx_q == IDX_W'(IDX_STAT_A) && wr_data != DATA_W'(A_DEFAULT))
      |=> ($stable(reg_a) && err));

  // R6
  cd_write_err_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_we && idx_q >= IDX_W'(IDX_STAT_C)) |=> err);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_b[B_PIE_BIT] |=> !irq);

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    dat_re |=> rd_valid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dat_re |=> !rd_valid);
endmodule

bind cmos_clock_regs cmos_clock_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
  .wr_data(wr_data), .rd_valid(rd_valid), .err(err), .irq(irq),
  .idx_q(idx_q), .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/cmos_clock_regs_tb.sv
module cmos_clock_regs_tb;
  localparam int TICK = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, rd_data_b;
  logic       rd_valid, rd_valid_b, err, err_b, irq, irq_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  cmos_clock_regs #(.TICK_CYCLES(TICK), .YEAR_BCD(1'b1)) u_dut (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .irq(irq));

  cmos_clock_regs #(.TICK_CYCLES(TICK), .YEAR_BCD(1'b0)) u_dut_bin (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
    .wr_data(wr_data), .rd_data(rd_data_b), .rd_valid(rd_valid_b), .err(err_b), .irq(irq_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v, output logic e);
    @(negedge clk); idx_we = 1'b1; wr_data = v;
    @(negedge clk); idx_we = 1'b0; e = err;
  endtask

  task automatic put(input logic [7:0] v, output logic e);
    @(negedge clk); dat_we = 1'b1; wr_data = v;
    @(negedge clk); dat_we = 1'b0; e = err;
  endtask

  task automatic get(output logic [7:0] v, output logic vld);
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0; v = rd_data; vld = rd_valid;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    logic       e, vld;
    logic [7:0] v, a_model, b_model, exp_v;
    logic [7:0] init_exp [10];
    logic [7:0] shadow [10];
    int         t0, gap, cnt;

    init_exp = '{8'd30, 8'd0, 8'd45, 8'd0, 8'd13, 8'd0, 8'd6, 8'd15, 8'd3, 8'h24};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!rd_valid && !err, "R10 reset outputs idle", {rd_valid, err}, 0);

    // R8 / R9: reset image
    for (int i = 0; i < 10; i++) begin
      set_idx(8'(i), e);
      get(v, vld);
      check(v == init_exp[i] && vld, $sformatf("R8 reset byte %0d", i), v, init_exp[i]);
      if (i == 9) begin
        check(rd_data_b == 8'd124, "R9 binary year", rd_data_b, 124);
        check(v == 8'h24, "R9 bcd year", v, 8'h24);
      end
    end

    // R2: byte array sweep
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 10; i++) begin
        shadow[i] = 8'((i * 37 + k * 91 + 5) & 255);
        set_idx(8'(i), e);
        put(shadow[i], e);
        check(!e, "R2 byte write no err", e, 0);
      end
      for (int i = 9; i >= 0; i--) begin
        set_idx(8'(i), e);
        get(v, vld);
        check(v == shadow[i], $sformatf("R2 byte %0d readback", i), v, shadow[i]);
      end
    end

    // R1: out-of-range index sweep keeps index 3
    set_idx(8'd3, e);
    check(!e, "R1 index 3 accepted", e, 0);
    for (int x = 14; x < 256; x++) begin
      set_idx(8'(x), e);
      check(e == 1'b1, $sformatf("R1 index 0x%0h flagged", x), e, 1);
    end
    get(v, vld);
    check(v == shadow[3], "R1 index kept after bad writes", v, shadow[3]);
    set_idx(8'd13, e);
    check(!e, "R1 index 13 accepted", e, 0);

    // R3: status A reset and toggling
    set_idx(8'd10, e);
    a_model = 8'h26;
    for (int r = 0; r < 4; r++) begin
      get(v, vld);
      a_model = a_model ^ 8'h80;
      check(v == a_model, "R3 status A read toggles", v, a_model);
    end

    // R4: status A write sweep
    for (int d = 0; d < 256; d++) begin
      put(8'(d), e);
      if (d == 8'h26) a_model = 8'h26;
      check(e == (d != 8'h26), $sformatf("R4 A write 0x%0h err", d), e, d != 8'h26);
      get(v, vld);
      a_model = a_model ^ 8'h80;
      check(v == a_model, $sformatf("R4 A after 0x%0h", d), v, a_model);
    end

    // R5: status B reset and write sweep
    set_idx(8'd11, e);
    get(v, vld);
    check(v == 8'h46, "R5 status B reset", v, 8'h46);
    b_model = 8'h46;
    for (int d = 0; d < 256; d++) begin
      logic ok;
      ok = ((8'(d) & ~8'h48) == 8'h06);
      put(8'(d), e);
      if (ok) b_model = 8'(d);
      check(e == !ok, $sformatf("R5 B write 0x%0h err", d), e, !ok);
      get(v, vld);
      check(v == b_model, $sformatf("R5 B after 0x%0h", d), v, b_model);
    end

    // R6: status C and D
    for (int s = 12; s < 14; s++) begin
      set_idx(8'(s), e);
      put(8'hFF, e);
      check(e == 1'b1, "R6 C/D write flagged", e, 1);
      get(v, vld);
      check(v == 8'h00 && vld, "R6 C/D read zero", v, 0);
    end

    // R7: disabled generator stays quiet
    set_idx(8'd11, e);
    put(8'h0E, e);
    cnt = 0;
    for (int c = 0; c < 4 * TICK; c++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    check(cnt == 0, "R7 no irq while disabled", cnt, 0);

    // R7: enabled generator period and width
    put(8'h46, e);
    t0 = -1;
    for (int c = 0; c < 4 * TICK && t0 < 0; c++) begin
      @(negedge clk);
      if (irq) t0 = c;
    end
    check(t0 >= 0, "R7 irq appears when enabled", t0, 0);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (gap == 1) check(!irq, "R7 irq single cycle", irq, 0);
    end while (!irq && gap < 4 * TICK);
    check(gap == TICK, "R7 irq period", gap, TICK);
    cnt = 0;
    for (int c = 0; c < 5 * TICK; c++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    check(cnt == 5, "R7 irq count over five periods", cnt, 5);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule